// File: doc/BRIEF.md
# BLDC Rotor Position Detector

This block watches a three-bit rotor position input, fed either by back-EMF comparators or by Hall sensors, and raises a one-cycle interrupt when it sees a rotor position event. A sampling run begins when the block is enabled and either an external timer start pulse or a software start bit arrives. A second timer pulse can end the run early. In match mode, an event is the qualified input becoming equal to a programmed expected pattern. In change mode, the block captures the input at the start of the run, and an event is the qualified input moving away from that captured pattern.

Sampling is qualified in one of three ways. In the first, every phase is sampled only while a shared PWM-on signal is high. In the second, every phase is sampled on every clock, which suits Hall sensors. In the third, each phase is sampled only inside its own lower-side conduction window, and that window opens a programmable number of clocks after the lower switch turns on. Each phase keeps the last bit it sampled while it is idle. Detection compares the mix of live and held bits.

Top module: `rotor_pos_detect`

## Requirements
- R1: A run starts (busy goes to 1 after the clock edge) only when enable is 1 and tmr_start or sw_start is 1 in that cycle. A start request while enable is 0 has no effect.
- R2: A tmr_stop pulse ends the run on the next edge without an interrupt. When tmr_stop and a start request arrive together, the stop wins.
- R3: In match mode (det_mode = 0), the block raises irq one clock after a cycle in which at least one phase samples and the live/held pattern equals the expected pattern latched at start.
- R4: In change mode (det_mode = 1), the block raises irq one clock after a cycle in which at least one phase samples and the live/held pattern differs from the input captured at start.
- R5: On every accepted start, start_pat takes the value pos_in had in the start cycle, and it holds that value until the next start.
- R6: irq lasts exactly one clock. Busy is 0 in the cycle irq is 1, and no further sampling happens until a new start.
- R7: When samp_mode = 2'b00, phases are sampled only in cycles where pwm_on is 1.
- R8: When samp_mode = 2'b01, all phases are sampled on every busy cycle.
- R9: When samp_mode = 2'b10, phase i is sampled from the (dly_cnt+1)-th cycle after the cycle in which the rising edge of low_on[i] is seen, for as long as low_on[i] stays 1. If low_on[i] falls first, that phase is not sampled. samp_mode = 2'b11 samples nothing.
- R10: A phase that is not sampling holds its last sampled bit. On start, the held bits are loaded with the reference pattern, which is the expected pattern in match mode and the captured input in change mode. Detection uses held bits for idle phases even when the live pin differs.
- R11: det_mode, samp_mode and expect_pat are latched at start. Changing them during a run has no effect on that run.
- R12: While enable is 0, the block is not busy, and an enable drop ends a run on the next edge without an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detection function enable |
| pos_in | input | POS_W | Rotor position input, one bit per phase |
| pwm_on | input | 1 | Shared PWM-on qualifier |
| low_on | input | POS_W | Per-phase lower-side conduction |
| tmr_start | input | 1 | Timer start pulse |
| tmr_stop | input | 1 | Timer stop pulse |
| sw_start | input | 1 | Software start command |
| det_mode | input | 1 | 0 = match, 1 = change from start pattern |
| samp_mode | input | 2 | 00 PWM-on, 01 every clock, 10 lower-side window, 11 none |
| expect_pat | input | POS_W | Expected position pattern |
| dly_cnt | input | DLY_W | Lower-side sampling delay in clocks |
| irq | output | 1 | One-cycle position-event pulse |
| busy | output | 1 | Sampling run in progress |
| start_pat | output | POS_W | Input pattern captured at start |

## Verification
Several properties are checked on every cycle: irq is a single-cycle pulse, it only follows a busy cycle, and busy is low when it fires. A stop pulse or a dropped enable always ends the run without an interrupt, an idle block does not start without a qualified start request, and every accepted start captures pos_in into start_pat. The following behaviours only show up in the directed scenarios: the exact delay before a lower-side window opens, a window that closes before the delay expires, the effect of held bits from an idle phase on detection, PWM-on gating, and the way changes to the configuration are ignored during a run.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  typedef enum logic [1:0] {
    SM_PWM  = 2'b00,
    SM_CONT = 2'b01,
    SM_LOW  = 2'b10,
    SM_NONE = 2'b11
  } samp_mode_e;

  typedef enum logic {
    DM_MATCH  = 1'b0,
    DM_CHANGE = 1'b1
  } det_mode_e;
endpackage

// File: rtl/rpd_phase_window.sv
// Per-phase lower-side window: reloads a delay on each rising edge of the
// conduction signal and opens once the delay has counted out.
module rpd_phase_window #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_on,
  input  logic [DLY_W-1:0] dly,
  output logic             win
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             prev_q;
  logic             rise;

  assign rise = low_on & ~prev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rise)
      cnt_d = dly;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= low_on;
    end
  end

  assign win = low_on & ~rise & (cnt_q == '0);
endmodule

// File: rtl/rpd_sample_qual.sv
// Chooses, per phase, whether the current cycle is a sampling cycle.
module rpd_sample_qual
  import rpd_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  samp_mode_e       mode,
  input  logic             active,
  input  logic             pwm_on,
  input  logic [POS_W-1:0] win,
  output logic [POS_W-1:0] samp
);
  for (genvar i = 0; i < POS_W; i++) begin : g_ph
    always_comb begin
      unique case (mode)
        SM_PWM:  samp[i] = active & pwm_on;
        SM_CONT: samp[i] = active;
        SM_LOW:  samp[i] = active & win[i];
        default: samp[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rpd_hold_cmp.sv
// Held per-phase bits, live/held merge and the event comparison.
module rpd_hold_cmp #(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic [POS_W-1:0] samp,
  input  logic [POS_W-1:0] pos_in,
  input  logic [POS_W-1:0] ref_pat,
  input  logic             change_mode,
  output logic             hit
);
  logic [POS_W-1:0] held_q, held_d;
  logic [POS_W-1:0] merged;

  for (genvar i = 0; i < POS_W; i++) begin : g_bit
    assign merged[i] = samp[i] ? pos_in[i] : held_q[i];
    always_comb begin
      if (load)
        held_d[i] = load_val[i];
      else if (samp[i])
        held_d[i] = pos_in[i];
      else
        held_d[i] = held_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign hit = (|samp) & (change_mode ? (merged != ref_pat) : (merged == ref_pat));
endmodule

// File: rtl/rotor_pos_detect.sv
module rotor_pos_detect
  import rpd_pkg::*;
#(
  parameter int POS_W = 3,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [POS_W-1:0] pos_in,
  input  logic             pwm_on,
  input  logic [POS_W-1:0] low_on,
  input  logic             tmr_start,
  input  logic             tmr_stop,
  input  logic             sw_start,
  input  logic             det_mode,
  input  logic [1:0]       samp_mode,
  input  logic [POS_W-1:0] expect_pat,
  input  logic [DLY_W-1:0] dly_cnt,
  output logic             irq,
  output logic             busy,
  output logic [POS_W-1:0] start_pat
);
  logic             active_q, active_d;
  logic             irq_q, irq_d;
  det_mode_e        det_q, det_d;
  samp_mode_e       sm_q, sm_d;
  logic [POS_W-1:0] exp_q, exp_d;
  logic [POS_W-1:0] cap_q, cap_d;

  logic             start_req, stop_req;
  logic [POS_W-1:0] win, samp;
  logic [POS_W-1:0] ref_pat, load_val;
  logic             hit;

  assign start_req = enable & (tmr_start | sw_start);
  assign stop_req  = tmr_stop | ~enable;

  for (genvar i = 0; i < POS_W; i++) begin : g_win
    rpd_phase_window #(.DLY_W(DLY_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .low_on (low_on[i]),
      .dly    (dly_cnt),
      .win    (win[i])
    );
  end

  rpd_sample_qual #(.POS_W(POS_W)) u_qual (
    .mode   (sm_q),
    .active (active_q),
    .pwm_on (pwm_on),
    .win    (win),
    .samp   (samp)
  );

  assign ref_pat  = (det_q == DM_CHANGE) ? cap_q : exp_q;
  assign load_val = (det_mode == 1'b1) ? pos_in : expect_pat;

  rpd_hold_cmp #(.POS_W(POS_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start_req & ~stop_req),
    .load_val    (load_val),
    .samp        (samp),
    .pos_in      (pos_in),
    .ref_pat     (ref_pat),
    .change_mode (det_q == DM_CHANGE),
    .hit         (hit)
  );

  always_comb begin
    active_d = active_q;
    irq_d    = 1'b0;
    det_d    = det_q;
    sm_d     = sm_q;
    exp_d    = exp_q;
    cap_d    = cap_q;
    if (stop_req) begin
      active_d = 1'b0;
    end else if (start_req) begin
      active_d = 1'b1;
      det_d    = det_mode_e'(det_mode);
      sm_d     = samp_mode_e'(samp_mode);
      exp_d    = expect_pat;
      cap_d    = pos_in;
    end else if (active_q && hit) begin
      active_d = 1'b0;
      irq_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      det_q    <= DM_MATCH;
      sm_q     <= SM_PWM;
      exp_q    <= '0;
      cap_q    <= '0;
    end else begin
      active_q <= active_d;
      irq_q    <= irq_d;
      det_q    <= det_d;
      sm_q     <= sm_d;
      exp_q    <= exp_d;
      cap_q    <= cap_d;
    end
  end

  assign irq       = irq_q;
  assign busy      = active_q;
  assign start_pat = cap_q;
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
  parameter int POS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             tmr_start,
  input logic             sw_start,
  input logic             tmr_stop,
  input logic [POS_W-1:0] pos_in,
  input logic             irq,
  input logic             busy,
  input logic [POS_W-1:0] start_pat
);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(enable && (tmr_start || sw_start))) |=> !busy);

  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_stop |=> (!busy && !irq));

  p_irq_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (tmr_start || sw_start) && !tmr_stop) |=> (busy && start_pat == $past(pos_in)));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  p_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !irq));
endmodule

bind rotor_pos_detect rpd_checker #(.POS_W(POS_W)) u_chk (.*);

// File: tb/rotor_pos_detect_test.sv
`timescale 1ns/1ps
module rotor_pos_detect_test;
  localparam int POS_W = 3;
  localparam int DLY_W = 8;

  logic             clk;
  logic             rst_n;
  logic             enable;
  logic [POS_W-1:0] pos_in;
  logic             pwm_on;
  logic [POS_W-1:0] low_on;
  logic             tmr_start, tmr_stop, sw_start;
  logic             det_mode;
  logic [1:0]       samp_mode;
  logic [POS_W-1:0] expect_pat;
  logic [DLY_W-1:0] dly_cnt;
  logic             irq, busy;
  logic [POS_W-1:0] start_pat;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  rotor_pos_detect #(.POS_W(POS_W), .DLY_W(DLY_W)) uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(input bit use_tmr);
    if (use_tmr) tmr_start = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    tmr_start = 1'b0;
    sw_start  = 1'b0;
  endtask

  task automatic go_idle();
    tmr_stop = 1'b1;
    @(negedge clk);
    tmr_stop = 1'b0;
    pwm_on = 1'b0;
    low_on = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R6 reset irq", irq, 0);
    chk("R1 reset busy", busy, 0);
    chk("R5 reset start_pat", start_pat, 0);
  endtask

  task automatic t_enable_gate();
    enable = 1'b0;
    do_start(0);
    chk("R1 start ignored while disabled", busy, 0);
    enable = 1'b1;
    nclk(1);
  endtask

  task automatic t_match_cont();
    det_mode = 0; samp_mode = 2'b01; expect_pat = 3'b101; pos_in = 3'b000;
    do_start(1);
    chk("R1 timer start sets busy", busy, 1);
    for (int i = 0; i < 3; i++) chk("R8 no match no irq", irq, 0);
    pos_in = 3'b101;
    nclk(1);
    chk("R3 match irq", irq, 1);
    chk("R6 busy clears at irq", busy, 0);
    nclk(1);
    chk("R6 irq single cycle", irq, 0);
    pos_in = 3'b000; nclk(1); pos_in = 3'b101; nclk(2);
    chk("R6 no irq after run ended", irq, 0);
    go_idle();
  endtask

  task automatic t_change_mode();
    det_mode = 1; samp_mode = 2'b01; expect_pat = 3'b000; pos_in = 3'b011;
    do_start(0);
    chk("R5 captured pattern", start_pat, 3);
    for (int i = 0; i < 3; i++) begin
      nclk(1);
      chk("R4 unchanged input no irq", irq, 0);
    end
    pos_in = 3'b010;
    nclk(1);
    chk("R4 change irq", irq, 1);
    chk("R5 start_pat held", start_pat, 3);
    go_idle();
  endtask

  task automatic t_pwm_mode();
    det_mode = 0; samp_mode = 2'b00; expect_pat = 3'b110; pos_in = 3'b110; pwm_on = 0;
    do_start(0);
    for (int i = 0; i < 3; i++) begin
      nclk(1);
      chk("R7 pwm off no sample", irq, 0);
    end
    pwm_on = 1'b1;
    nclk(1);
    chk("R7 pwm on sample irq", irq, 1);
    go_idle();
  endtask

  task automatic t_low_delay();
    det_mode = 0; samp_mode = 2'b10; expect_pat = 3'b001; pos_in = 3'b001;
    low_on = 3'b000; dly_cnt = 8'd3;
    do_start(0);
    nclk(2);
    chk("R9 no window before conduction", irq, 0);
    low_on = 3'b001;
    for (int i = 1; i <= 4; i++) begin
      nclk(1);
      chk("R9 delay not elapsed", irq, 0);
    end
    nclk(1);
    chk("R9 window opens after delay", irq, 1);
    go_idle();
    do_start(0);
    low_on = 3'b001;
    nclk(2);
    low_on = 3'b000;
    nclk(6);
    chk("R9 short conduction no sample", irq, 0);
    chk("R9 run still busy", busy, 1);
    samp_mode = 2'b11;
    go_idle();
    do_start(0);
    nclk(4);
    chk("R9 mode 11 samples nothing", irq, 0);
    go_idle();
  endtask

  task automatic t_hold();
    det_mode = 0; samp_mode = 2'b10; expect_pat = 3'b011; pos_in = 3'b000;
    low_on = 3'b000; dly_cnt = 8'd0;
    do_start(0);
    low_on = 3'b010;
    for (int i = 0; i < 3; i++) begin
      nclk(1);
      chk("R10 phase1 sampled wrong bit", irq, 0);
    end
    low_on = 3'b001; pos_in = 3'b011;
    for (int i = 0; i < 3; i++) begin
      nclk(1);
      chk("R10 held phase1 bit blocks match", irq, 0);
    end
    low_on = 3'b011;
    nclk(1);
    chk("R10 phase1 window not yet open", irq, 0);
    nclk(1);
    chk("R10 live and held bits match", irq, 1);
    go_idle();
  endtask

  task automatic t_cfg_latch();
    det_mode = 0; samp_mode = 2'b01; expect_pat = 3'b111; pos_in = 3'b000;
    do_start(0);
    expect_pat = 3'b000; samp_mode = 2'b11; det_mode = 1;
    for (int i = 0; i < 3; i++) begin
      nclk(1);
      chk("R11 new config ignored", irq, 0);
    end
    chk("R11 still busy", busy, 1);
    pos_in = 3'b111;
    nclk(1);
    chk("R11 latched config detects", irq, 1);
    go_idle();
  endtask

  task automatic t_stop();
    det_mode = 0; samp_mode = 2'b01; expect_pat = 3'b101; pos_in = 3'b000;
    do_start(0);
    tmr_stop = 1'b1; pos_in = 3'b101;
    nclk(1);
    tmr_stop = 1'b0;
    chk("R2 stop clears busy", busy, 0);
    chk("R2 stop no irq", irq, 0);
    nclk(2);
    chk("R2 no irq after stop", irq, 0);
    tmr_start = 1'b1; tmr_stop = 1'b1;
    nclk(1);
    tmr_start = 1'b0; tmr_stop = 1'b0;
    chk("R2 stop beats start", busy, 0);
    nclk(1);
  endtask

  task automatic t_enable_drop();
    det_mode = 0; samp_mode = 2'b01; expect_pat = 3'b111; pos_in = 3'b000;
    do_start(0);
    chk("R12 busy before drop", busy, 1);
    enable = 1'b0; pos_in = 3'b111;
    nclk(1);
    chk("R12 enable drop clears busy", busy, 0);
    chk("R12 enable drop no irq", irq, 0);
    enable = 1'b1;
    nclk(1);
  endtask

  initial begin
    rst_n = 0; enable = 1; pos_in = '0; pwm_on = 0; low_on = '0;
    tmr_start = 0; tmr_stop = 0; sw_start = 0; det_mode = 0;
    samp_mode = 2'b01; expect_pat = '0; dly_cnt = '0;
    nclk(3);
    rst_n = 1;
    nclk(1);
    t_reset();
    t_enable_gate();
    t_match_cont();
    t_change_mode();
    t_pwm_mode();
    t_low_delay();
    t_hold();
    t_cfg_latch();
    t_stop();
    t_enable_drop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule